// File: doc/BRIEF.md
# Double-Rate Write/Read Data Gearbox

This block sits between a single-rate memory-controller core and a double-rate data pin bus. On the write side it takes one core word of twice the pin width per core clock. It sends that word as two pin beats, one per clock half. It drives a strobe whose edges fall in the middle of each beat, along with per-lane mask bits that follow the same double-rate timing. The write burst length is set per burst from a two-bit code. The block counts off the words of the burst by itself, so the core only signals the start of the burst and then presents one word per cycle.

On the read side the memory sends beats with a strobe whose edges line up with the data transitions. Each byte lane has its own strobe. Each lane first delays its strobe by a fixed number of taps of a fast sampling clock, which moves the edges to the middle of the data eye. It then captures the beat present at the rising edge and the beat present at the falling edge in two separate registers. These are merged into a full-width word and handed to the core clock domain with a one-cycle valid pulse.

Top module: `ddr_prefetch_dp`

## Requirements
- R1: A write burst starts when `wr_go_i` is high in a cycle with no burst running. The `wr_bl_i` code 0 gives 1 word (2 beats), code 1 gives 2 words (4 beats), and codes 2 and 3 give 4 words (8 beats). Words are taken on consecutive core clock edges, the first on the edge that samples `wr_go_i`. `dq_oe_o` is high for exactly that many core cycles.
- R2: A word sampled on core edge t is driven on `dq_o` during the cycle that starts at edge t+1. Bits [n-1:0] are driven while `clk_i` is high (first beat) and bits [2n-1:n] while `clk_i` is low (second beat).
- R3: In each core cycle that carries write data, `dqs_o` is low for the first quarter cycle, high from the quarter point to the three-quarter point, and low after that. Outside such cycles it is low.
- R4: `dqs_oe_o` rises half a core cycle before the first beat of a burst. It falls half a core cycle after the last beat ends, and stays low while no burst is running.
- R5: `wr_mask_i` bits [L-1:0] (one per byte lane) go out on `dm_o` with the first beat, and bits [2L-1:L] with the second beat. A high bit marks that lane as not written for that beat.
- R6: For each lane, the byte present at the delayed rising strobe edge becomes that lane's byte in the low half of the read word. The byte present at the delayed falling edge becomes that lane's byte in the high half.
- R7: `rd_valid_o` is high for exactly one core cycle per captured word. It is high during the core cycle that follows the cycle in which the word's falling strobe edge arrived, and `rd_data_o` holds the word in that cycle. With no strobe edges, it stays low.
- R8: While `rst_ni` is low, `dq_oe_o`, `dqs_oe_o`, `dqs_o` and `rd_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; also launches write data beats |
| clk90_i | input | 1 | Core clock shifted by a quarter period; launches write strobe edges |
| clk_dly_i | input | 1 | Fast tap clock for the read strobe delay line |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_go_i | input | 1 | Start of a write burst |
| wr_bl_i | input | 2 | Write burst length code |
| wr_data_i | input | 2*LANE_W*LANES | Core write word |
| wr_mask_i | input | 2*LANES | Per-beat, per-lane write mask |
| dq_o | output | LANE_W*LANES | Write data beats to the pins |
| dq_oe_o | output | 1 | Data pin output enable |
| dm_o | output | LANES | Mask beats to the pins |
| dqs_o | output | LANES | Write strobe per lane |
| dqs_oe_o | output | LANES | Strobe output enable per lane |
| dq_i | input | LANE_W*LANES | Read data beats from the pins |
| dqs_i | input | LANES | Read strobe per lane |
| rd_valid_o | output | 1 | One pulse per reassembled read word |
| rd_data_o | output | 2*LANE_W*LANES | Reassembled read word |

## Verification
The bench builds the block with two 8-bit lanes and a two-tap read delay, with a tap clock at eight times the core rate, so the delay is exactly a quarter cycle. With only four words per burst, every burst-length code, including the code that falls back to eight beats, can be swept against several mask patterns that hit both lanes in both beats. Each written burst is stored in a model memory through the observed mask and data pins and then read back through the capture path. The strobe is sampled on both sides of its quarter and three-quarter points, which makes the centring and the preamble and postamble windows visible.

// File: rtl/ddr_dp_pkg.sv
`timescale 1ns/1ps
package ddr_dp_pkg;
  // burst code -> core words per burst
  function automatic logic [2:0] bl_words(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ddr_wr_gear.sv
`timescale 1ns/1ps
module ddr_wr_gear
  import ddr_dp_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk_i,
  input  logic                      clk90_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  logic [1:0]                bl_i,
  input  logic [2*LANE_W*LANES-1:0] data_i,
  input  logic [2*LANES-1:0]        mask_i,
  output logic [LANE_W*LANES-1:0]   dq_o,
  output logic                      dq_oe_o,
  output logic [LANES-1:0]          dm_o,
  output logic [LANES-1:0]          dqs_o,
  output logic [LANES-1:0]          dqs_oe_o
);
  localparam int N = LANE_W * LANES;

  logic [1:0]         left_q;
  logic               accept;
  logic               s1_v, s2_v;
  logic [2*N-1:0]     s1_d, s2_d;
  logic [2*LANES-1:0] s1_m, s2_m;
  logic               oe_q;
  logic [2:0]         words;

  assign words  = bl_words(bl_i);
  assign accept = go_i | (left_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s1_d   <= '0;
      s2_d   <= '0;
      s1_m   <= '0;
      s2_m   <= '0;
    end else begin
      if (left_q != 2'd0) left_q <= left_q - 2'd1;
      else if (go_i)      left_q <= 2'(words - 3'd1);
      s1_v <= accept;
      s1_d <= data_i;
      s1_m <= mask_i;
      s2_v <= s1_v;
      s2_d <= s1_d;
      s2_m <= s1_m;
    end
  end

  // half-cycle preamble/postamble: sample on falling core edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= s1_v | s2_v;
  end

  // clock-selected output gear: first beat while clk high
  assign dq_o    = clk_i ? s2_d[N-1:0] : s2_d[2*N-1:N];
  assign dm_o    = clk_i ? s2_m[LANES-1:0] : s2_m[2*LANES-1:LANES];
  assign dq_oe_o = s2_v;

  // s2_v changes while clk90 is low, so gating is glitch-free
  for (genvar l = 0; l < LANES; l++) begin : g_strobe
    assign dqs_o[l]    = s2_v & clk90_i;
    assign dqs_oe_o[l] = oe_q;
  end
endmodule

// File: rtl/ddr_lane_capture.sv
`timescale 1ns/1ps
module ddr_lane_capture #(
  parameter int LANE_W   = 8,
  parameter int DLY_TAPS = 2
) (
  input  logic                clk_dly_i,
  input  logic                rst_ni,
  input  logic                dqs_i,
  input  logic [LANE_W-1:0]   dq_i,
  output logic [2*LANE_W-1:0] word_o,
  output logic                tgl_o
);
  logic [DLY_TAPS-1:0] tap_q;
  logic                dqs_dly;
  logic [LANE_W-1:0]   rise_q;

  for (genvar k = 0; k < DLY_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_first
      always_ff @(posedge clk_dly_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[0] <= 1'b0;
        else         tap_q[0] <= dqs_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_dly_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[k] <= 1'b0;
        else         tap_q[k] <= tap_q[k-1];
      end
    end
  end
  assign dqs_dly = tap_q[DLY_TAPS-1];

  always_ff @(posedge dqs_dly or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= dq_i;
  end

  // falling edge completes the pair
  always_ff @(negedge dqs_dly or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      tgl_o  <= 1'b0;
    end else begin
      word_o <= {dq_i, rise_q};
      tgl_o  <= ~tgl_o;
    end
  end
endmodule

// File: rtl/ddr_prefetch_dp.sv
`timescale 1ns/1ps
module ddr_prefetch_dp #(
  parameter int LANE_W   = 8,
  parameter int LANES    = 2,
  parameter int DLY_TAPS = 2
) (
  input  logic                      clk_i,
  input  logic                      clk90_i,
  input  logic                      clk_dly_i,
  input  logic                      rst_ni,
  input  logic                      wr_go_i,
  input  logic [1:0]                wr_bl_i,
  input  logic [2*LANE_W*LANES-1:0] wr_data_i,
  input  logic [2*LANES-1:0]        wr_mask_i,
  output logic [LANE_W*LANES-1:0]   dq_o,
  output logic                      dq_oe_o,
  output logic [LANES-1:0]          dm_o,
  output logic [LANES-1:0]          dqs_o,
  output logic [LANES-1:0]          dqs_oe_o,
  input  logic [LANE_W*LANES-1:0]   dq_i,
  input  logic [LANES-1:0]          dqs_i,
  output logic                      rd_valid_o,
  output logic [2*LANE_W*LANES-1:0] rd_data_o
);
  localparam int N = LANE_W * LANES;

  ddr_wr_gear #(.LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk_i    (clk_i),
    .clk90_i  (clk90_i),
    .rst_ni   (rst_ni),
    .go_i     (wr_go_i),
    .bl_i     (wr_bl_i),
    .data_i   (wr_data_i),
    .mask_i   (wr_mask_i),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o),
    .dm_o     (dm_o),
    .dqs_o    (dqs_o),
    .dqs_oe_o (dqs_oe_o)
  );

  logic [2*LANE_W-1:0] lane_word [LANES];
  logic [LANES-1:0]    lane_tgl;
  logic [2*N-1:0]      cap_word;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ddr_lane_capture #(.LANE_W(LANE_W), .DLY_TAPS(DLY_TAPS)) u_cap (
      .clk_dly_i (clk_dly_i),
      .rst_ni    (rst_ni),
      .dqs_i     (dqs_i[l]),
      .dq_i      (dq_i[l*LANE_W +: LANE_W]),
      .word_o    (lane_word[l]),
      .tgl_o     (lane_tgl[l])
    );
    assign cap_word[l*LANE_W +: LANE_W]     = lane_word[l][LANE_W-1:0];
    assign cap_word[N + l*LANE_W +: LANE_W] = lane_word[l][2*LANE_W-1:LANE_W];
  end

  // lane 0 toggle marks word completion; lanes share one burst timing
  logic           tgl_s, tgl_p;
  logic [2*N-1:0] word_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_s  <= 1'b0;
      tgl_p  <= 1'b0;
      word_s <= '0;
    end else begin
      tgl_s  <= lane_tgl[0];
      tgl_p  <= tgl_s;
      word_s <= cap_word;
    end
  end

  assign rd_valid_o = tgl_s ^ tgl_p;
  assign rd_data_o  = word_s;
endmodule

// File: rtl/ddr_prefetch_dp_chk.sv
`timescale 1ns/1ps
module ddr_prefetch_dp_chk #(
  parameter int LANES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_go_i,
  input logic             dq_oe_o,
  input logic [LANES-1:0] dqs_o,
  input logic [LANES-1:0] dqs_oe_o
);
  // R1: data enable only ever starts two edges after a start request
  a_r1_start_from_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(wr_go_i, 2));

  // R4: strobe enable already up one edge before data enable rises
  a_r4_preamble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_oe_o[0]));

  // R4: strobe enable covers every data cycle
  a_r4_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o[0]);

  // R3: strobe is low at each data launch edge
  a_r3_low_at_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_o == '0);
endmodule

bind ddr_prefetch_dp ddr_prefetch_dp_chk #(.LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_go_i  (wr_go_i),
  .dq_oe_o  (dq_oe_o),
  .dqs_o    (dqs_o),
  .dqs_oe_o (dqs_oe_o)
);

// File: tb/ddr_prefetch_dp_tb_top.sv
`timescale 1ns/1ps
module ddr_prefetch_dp_tb_top;
  localparam int LW = 8;
  localparam int LN = 2;
  localparam int N  = LW * LN;
  localparam int W2 = 2 * N;

  logic clk = 1'b0, clk90 = 1'b0, clk_dly = 1'b1, rst_n = 1'b0;
  logic          wr_go = 1'b0;
  logic [1:0]    wr_bl = '0;
  logic [W2-1:0] wr_data = '0;
  logic [3:0]    wr_mask = '0;
  logic [N-1:0]  dq_in = '0;
  logic [LN-1:0] dqs_in = '0;
  logic [N-1:0]  dq_out;
  logic          dq_oe;
  logic [LN-1:0] dm_out, dqs_out, dqs_oe;
  logic          rd_valid;
  logic [W2-1:0] rd_data;

  initial forever #10 clk = ~clk;
  initial begin #5; forever #10 clk90 = ~clk90; end
  initial forever #1.25 clk_dly = ~clk_dly;

  ddr_prefetch_dp #(.LANE_W(LW), .LANES(LN), .DLY_TAPS(2)) dut_i (
    .clk_i(clk), .clk90_i(clk90), .clk_dly_i(clk_dly), .rst_ni(rst_n),
    .wr_go_i(wr_go), .wr_bl_i(wr_bl), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dm_o(dm_out), .dqs_o(dqs_out),
    .dqs_oe_o(dqs_oe), .dq_i(dq_in), .dqs_i(dqs_in),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [W2-1:0] pin_mem [4];
  logic [W2-1:0] exp_mem [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nwords(input int bl);
    return (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
  endfunction

  task automatic run_write(input int bl, input int seed);
    int w;
    logic [W2-1:0] d [4];
    logic [3:0]    m [4];
    w = nwords(bl);
    for (int i = 0; i < 4; i++) begin
      d[i] = 32'h9E37_79B9 * (seed * 8 + i + 1 + bl * 40);
      m[i] = (seed == 0) ? 4'h0 : 4'((seed * 5 + i * 3 + bl) & 15);
    end
    for (int i = 0; i < w; i++)
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < LN; l++)
          if (!m[i][b*LN + l]) exp_mem[i][b*N + l*LW +: LW] = d[i][b*N + l*LW +: LW];
    @(negedge clk);
    fork
      begin
        wr_go = 1'b1; wr_bl = 2'(bl); wr_data = d[0]; wr_mask = m[0];
        for (int i = 1; i < w; i++) begin
          @(negedge clk);
          wr_go = 1'b0; wr_data = d[i]; wr_mask = m[i];
        end
        @(negedge clk);
        wr_go = 1'b0; wr_data = '0; wr_mask = '0;
      end
      begin
        @(posedge clk);  // t0: first word sampled
        #7;  chk("R4 pre-off", {31'b0, dqs_oe[0]}, 32'd0);
        #6;  chk("R4 preamble", {30'b0, dqs_oe}, 32'd3);
             chk("R1 oe-before", {31'b0, dq_oe}, 32'd0);
             chk("R3 preamble-low", {30'b0, dqs_out}, 32'd0);
        #7;
        for (int i = 0; i < w; i++) begin
          #3;  chk("R1 oe", {31'b0, dq_oe}, 32'd1);
               chk("R2 beat0", {16'b0, dq_out}, {16'b0, d[i][N-1:0]});
               chk("R5 mask0", {30'b0, dm_out}, {30'b0, m[i][1:0]});
               chk("R3 q1-low", {30'b0, dqs_out}, 32'd0);
          #4;  chk("R3 mid0-high", {30'b0, dqs_out}, 32'd3);
               for (int l = 0; l < LN; l++)
                 if (!dm_out[l]) pin_mem[i][l*LW +: LW] = dq_out[l*LW +: LW];
          #6;  chk("R2 beat1", {16'b0, dq_out}, {16'b0, d[i][W2-1:N]});
               chk("R5 mask1", {30'b0, dm_out}, {30'b0, m[i][3:2]});
               chk("R3 mid1-high", {30'b0, dqs_out}, 32'd3);
               for (int l = 0; l < LN; l++)
                 if (!dm_out[l]) pin_mem[i][N + l*LW +: LW] = dq_out[l*LW +: LW];
          #4;  chk("R3 q4-low", {30'b0, dqs_out}, 32'd0);
          #3;
        end
        #3;  chk("R1 oe-after", {31'b0, dq_oe}, 32'd0);
        #4;  chk("R4 postamble", {30'b0, dqs_oe}, 32'd3);
             chk("R3 post-low", {30'b0, dqs_out}, 32'd0);
        #6;  chk("R4 post-off", {30'b0, dqs_oe}, 32'd0);
      end
    join
  endtask

  task automatic run_read(input int bl);
    int w, cnt;
    w = nwords(bl);
    cnt = 0;
    fork
      begin
        @(posedge clk);
        for (int j = 0; j < w; j++) begin
          #1;  dq_in = pin_mem[j][N-1:0];  dqs_in = '1;
          #10; dq_in = pin_mem[j][W2-1:N]; dqs_in = '0;
          #9;
        end
        #1; dq_in = '0;
      end
      begin
        @(posedge clk);
        for (int c = 0; c < w + 3; c++) begin
          @(posedge clk);
          #3;
          chk("R7 valid", {31'b0, rd_valid}, (c < w) ? 32'd1 : 32'd0);
          if (rd_valid && cnt < w) begin
            chk("R6 word", rd_data, exp_mem[cnt]);
            cnt++;
          end
        end
        chk("R7 count", 32'(cnt), 32'(w));
      end
    join
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=%0d exp=0", $time);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      pin_mem[k] = 32'hA5C3_0000 + 32'(k) * 32'h0111;
      exp_mem[k] = pin_mem[k];
    end
    #55;
    chk("R8 dq_oe", {31'b0, dq_oe}, 32'd0);
    chk("R8 dqs_oe", {30'b0, dqs_oe}, 32'd0);
    chk("R8 dqs", {30'b0, dqs_out}, 32'd0);
    chk("R8 rd_valid", {31'b0, rd_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 idle", {31'b0, rd_valid}, 32'd0);
    for (int bl = 0; bl < 4; bl++)
      for (int seed = 0; seed < 4; seed++) begin
        run_write(bl, seed);
        repeat (2) @(negedge clk);
        run_read(bl);
        repeat (2) @(negedge clk);
      end
    finish_run();
  end
endmodule